// File: doc/BRIEF.md
# Cache Way Lockdown Victim Selector

This block sits beside a set-associative cache and decides which way receives each line fill. It keeps two lockdown index registers, one for the instruction cache and one for the data cache. Software reads and writes them through a small coprocessor-style register port. A register's value is a way number. Every way numbered below it is protected and never evicted. Normal replacement picks its victim only among the ways from the index up to the highest way.

Each cache has its own round-robin pointer over its unlocked ways. A normal miss takes the way under the pointer, lifted to the index if the pointer lies below it. The pointer then steps to the next way and wraps from the highest way back to the index.

To load content that will later be locked, software raises the load-lock input with a miss. That fill goes to exactly the indexed way, and the pointer is left alone. Software then raises the index to lock the freshly loaded way. An index written at or beyond the number of ways is clamped to the highest way, so one way always stays replaceable.

Top module: `lkv_victim_sel`

## Requirements
- R1: After reset both lockdown indices read as 0 and both round-robin pointers are at way 0. `victim_valid` is low until the first miss.
- R2: A register access addresses the data-cache index when `cp_opc2` is 0 and the instruction-cache index when `cp_opc2` is 1, in both cases only with `cp_crm` equal to 0. A write takes the index from `cp_wdata[7:0]`.
- R3: A read with `cp_rd` high updates `cp_rdata` on the next clock edge. For a valid address, `cp_rdata` holds the index zero-extended in bits [WAY_W-1:0] with all other bits 0. For any other address it reads as all zeros.
- R4: A write with `cp_crm` not 0 or `cp_opc2` above 1 changes neither index. Both indices read back unchanged afterwards.
- R5: A written index field at or above NUM_WAYS is stored as NUM_WAYS-1.
- R6: A cycle with `miss_req` high produces `victim_valid` high with `victim_way` on the next clock edge. `victim_valid` is low after any cycle without a miss.
- R7: On a normal miss (`miss_loadlock` low), the victim is never below the index of the cache selected by `miss_icache` (1 = instruction, 0 = data).
- R8: On a normal miss, the victim is the cache's pointer, or the index if the pointer lies below it. The pointer then moves to victim+1, or back to the index when the victim is NUM_WAYS-1. Each cache keeps its own pointer.
- R9: On a miss with `miss_loadlock` high, the victim equals the selected cache's index exactly, and that cache's pointer does not move.
- R10: When a register write and a miss fall in the same cycle, the miss uses the index value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_wr | input | 1 | Register write strobe |
| cp_rd | input | 1 | Register read strobe |
| cp_opc2 | input | 3 | Register select: 0 data index, 1 instruction index |
| cp_crm | input | 4 | Secondary register field, must be 0 |
| cp_wdata | input | 32 | Write data, index in bits [7:0] |
| cp_rdata | output | 32 | Registered read data |
| miss_req | input | 1 | Cache miss needing a victim |
| miss_icache | input | 1 | 1 for the instruction cache, 0 for the data cache |
| miss_loadlock | input | 1 | Fill the indexed way exactly (lock loading) |
| victim_valid | output | 1 | Victim way valid, one cycle after `miss_req` |
| victim_way | output | WAY_W | Way chosen to receive the fill |

## Verification
Runs of misses with index 0 walk the whole way range and show the wrap back to way 0. Runs with a raised index show that locked ways are skipped and that the wrap returns to the index rather than to 0. A pointer left below a newly raised index shows the lift to the index. Interleaving data and instruction misses tells apart two independent pointers from one shared pointer. Load-lock misses followed by normal misses show that locked loading hits the index exactly and leaves the rotation where it was. A write landing in the same cycle as a miss separates use of the old index from the new one.

// File: rtl/lkv_pkg.sv
package lkv_pkg;

    // Which lockdown register a coprocessor access addresses
    typedef enum logic [1:0] {
        TGT_DATA  = 2'd0,
        TGT_INSTR = 2'd1,
        TGT_NONE  = 2'd2
    } lkv_target_e;

    // Decoded register access
    typedef struct packed {
        logic        wr;
        logic        rd;
        lkv_target_e tgt;
    } lkv_access_t;

    // Miss request as seen by one replacement unit
    typedef struct packed {
        logic req;
        logic loadlock;
    } lkv_miss_t;

    localparam int unsigned LKV_DATA_IDX  = 0;
    localparam int unsigned LKV_INSTR_IDX = 1;
    localparam int unsigned LKV_NUM_CACHE = 2;

    // Decode the secondary field and second opcode into a target
    function automatic lkv_target_e lkv_decode(input logic [2:0] opc2,
                                               input logic [3:0] crm);
        lkv_target_e t;
        t = TGT_NONE;
        if (crm == 4'd0) begin
            if (opc2 == 3'd0)
                t = TGT_DATA;
            else if (opc2 == 3'd1)
                t = TGT_INSTR;
        end
        return t;
    endfunction

    // Clamp a raw index field to the highest way
    function automatic int unsigned lkv_clamp(input int unsigned raw,
                                              input int unsigned nways);
        int unsigned r;
        if (raw >= nways)
            r = nways - 1;
        else
            r = raw;
        return r;
    endfunction

endpackage

// File: rtl/lkv_lock_regs.sv
module lkv_lock_regs
    import lkv_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned FIELD_W  = 8,
    parameter int unsigned WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cp_wr,
    input  logic                                 cp_rd,
    input  logic [2:0]                           cp_opc2,
    input  logic [3:0]                           cp_crm,
    input  logic [31:0]                          cp_wdata,
    output logic [31:0]                          cp_rdata,
    output logic [LKV_NUM_CACHE-1:0][WAY_W-1:0]  idx_o
);

    localparam int unsigned PAD_W = 32 - WAY_W;

    lkv_access_t                          acc;
    logic [LKV_NUM_CACHE-1:0][WAY_W-1:0]  idx_q;
    logic [WAY_W-1:0]                     wr_val;
    logic [31:0]                          rd_next;
    logic [31:0]                          rdata_q;
    logic [FIELD_W-1:0]                   raw_field;

    always_comb begin
        acc.wr  = cp_wr;
        acc.rd  = cp_rd;
        acc.tgt = lkv_decode(cp_opc2, cp_crm);
    end

    // Clamp the written field so at least one way stays replaceable
    assign raw_field = cp_wdata[FIELD_W-1:0];
    always_comb begin
        wr_val = WAY_W'(lkv_clamp(int'(raw_field), NUM_WAYS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (acc.wr) begin
            case (acc.tgt)
                TGT_DATA:  idx_q[LKV_DATA_IDX]  <= wr_val;
                TGT_INSTR: idx_q[LKV_INSTR_IDX] <= wr_val;
                default:   idx_q <= idx_q;
            endcase
        end
    end

    always_comb begin
        case (acc.tgt)
            TGT_DATA:  rd_next = {{PAD_W{1'b0}}, idx_q[LKV_DATA_IDX]};
            TGT_INSTR: rd_next = {{PAD_W{1'b0}}, idx_q[LKV_INSTR_IDX]};
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (acc.rd)
            rdata_q <= rd_next;
    end

    assign cp_rdata = rdata_q;
    assign idx_o    = idx_q;

    // Writes to an address other than the two lock registers leave both untouched
    assert_ignored_write_R4: assert property (@(posedge clk) disable iff (rst)
        (cp_wr && (cp_crm != 4'd0 || cp_opc2 > 3'd1)) |=> $stable(idx_q));

    // A stored index never points past the highest way
    assert_index_clamped_R5: assert property (@(posedge clk) disable iff (rst)
        (32'(idx_q[LKV_DATA_IDX]) < NUM_WAYS) && (32'(idx_q[LKV_INSTR_IDX]) < NUM_WAYS));

    // Reads of an unknown address return zero
    assert_bad_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cp_rd && cp_crm != 4'd0) |=> (cp_rdata == 32'd0));

endmodule

// File: rtl/lkv_rr_unit.sv
module lkv_rr_unit
    import lkv_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  lkv_miss_t        miss,
    input  logic [WAY_W-1:0] idx,
    output logic [WAY_W-1:0] victim
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

    logic [WAY_W-1:0] ptr_q;
    logic [WAY_W-1:0] ptr_lifted;
    logic [WAY_W-1:0] ptr_next;

    // A pointer left in the locked region is lifted to the first free way
    assign ptr_lifted = (ptr_q < idx) ? idx : ptr_q;

    always_comb begin
        if (miss.loadlock)
            victim = idx;
        else
            victim = ptr_lifted;
    end

    always_comb begin
        if (ptr_lifted == LAST_WAY)
            ptr_next = idx;
        else
            ptr_next = ptr_lifted + WAY_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (miss.req && !miss.loadlock)
            ptr_q <= ptr_next;
    end

    // Lock loading does not disturb the rotation
    assert_loadlock_keeps_ptr_R9: assert property (@(posedge clk) disable iff (rst)
        (miss.req && miss.loadlock) |=> $stable(ptr_q));

    // The pointer stays inside the way range
    assert_ptr_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        32'(ptr_q) < NUM_WAYS);

    // Without a miss the pointer holds
    assert_ptr_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !miss.req |=> $stable(ptr_q));

endmodule

// File: rtl/lkv_victim_sel.sv
module lkv_victim_sel
    import lkv_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned FIELD_W  = 8,
    parameter int unsigned WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cp_wr,
    input  logic             cp_rd,
    input  logic [2:0]       cp_opc2,
    input  logic [3:0]       cp_crm,
    input  logic [31:0]      cp_wdata,
    output logic [31:0]      cp_rdata,
    input  logic             miss_req,
    input  logic             miss_icache,
    input  logic             miss_loadlock,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way
);

    logic [LKV_NUM_CACHE-1:0][WAY_W-1:0] idx;
    logic [LKV_NUM_CACHE-1:0][WAY_W-1:0] cand;
    logic [WAY_W-1:0]                    sel_idx;
    logic                                valid_q;
    logic [WAY_W-1:0]                    way_q;

    lkv_lock_regs #(
        .NUM_WAYS (NUM_WAYS),
        .FIELD_W  (FIELD_W),
        .WAY_W    (WAY_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cp_wr    (cp_wr),
        .cp_rd    (cp_rd),
        .cp_opc2  (cp_opc2),
        .cp_crm   (cp_crm),
        .cp_wdata (cp_wdata),
        .cp_rdata (cp_rdata),
        .idx_o    (idx)
    );

    // One replacement unit per cache, each with its own pointer
    for (genvar g = 0; g < LKV_NUM_CACHE; g++) begin : g_rr
        lkv_miss_t m;
        logic      mine;
        assign mine       = (g == LKV_INSTR_IDX) ? miss_icache : !miss_icache;
        assign m.req      = miss_req && mine;
        assign m.loadlock = miss_loadlock;

        lkv_rr_unit #(
            .NUM_WAYS (NUM_WAYS),
            .WAY_W    (WAY_W)
        ) u_rr (
            .clk    (clk),
            .rst    (rst),
            .miss   (m),
            .idx    (idx[g]),
            .victim (cand[g])
        );
    end

    assign sel_idx = miss_icache ? idx[LKV_INSTR_IDX] : idx[LKV_DATA_IDX];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            way_q   <= '0;
        end else begin
            valid_q <= miss_req;
            if (miss_req)
                way_q <= miss_icache ? cand[LKV_INSTR_IDX] : cand[LKV_DATA_IDX];
        end
    end

    assign victim_valid = valid_q;
    assign victim_way   = way_q;

    // Every miss yields a victim one cycle later
    assert_miss_answered_R6: assert property (@(posedge clk) disable iff (rst)
        miss_req |=> victim_valid);

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        !miss_req |=> !victim_valid);

    // Normal replacement never lands in a locked way
    assert_victim_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
        (miss_req && !miss_loadlock) |=> (victim_way >= $past(sel_idx)));

    // Lock loading fills exactly the indexed way
    assert_loadlock_exact_R9: assert property (@(posedge clk) disable iff (rst)
        (miss_req && miss_loadlock) |=> (victim_way == $past(sel_idx)));

endmodule

// File: tb/tb_lkv_victim_sel.sv
module tb_lkv_victim_sel;

    localparam int CLK_PERIOD = 10;
    localparam int NWAYS      = 4;
    localparam int WW         = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cp_wr = 1'b0;
    logic          cp_rd = 1'b0;
    logic [2:0]    cp_opc2 = '0;
    logic [3:0]    cp_crm = '0;
    logic [31:0]   cp_wdata = '0;
    logic [31:0]   cp_rdata;
    logic          miss_req = 1'b0;
    logic          miss_icache = 1'b0;
    logic          miss_loadlock = 1'b0;
    logic          victim_valid;
    logic [WW-1:0] victim_way;

    int n_checks = 0;
    int n_fail   = 0;
    int m_idx [2];
    int m_ptr [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    lkv_victim_sel #(.NUM_WAYS(NWAYS)) dut (
        .clk(clk), .rst(rst),
        .cp_wr(cp_wr), .cp_rd(cp_rd), .cp_opc2(cp_opc2), .cp_crm(cp_crm),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
        .miss_req(miss_req), .miss_icache(miss_icache), .miss_loadlock(miss_loadlock),
        .victim_valid(victim_valid), .victim_way(victim_way)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic wr_reg(input int opc2, input int crm, input int val);
        @(negedge clk);
        cp_wr = 1'b1; cp_opc2 = 3'(opc2); cp_crm = 4'(crm); cp_wdata = 32'(val);
        @(negedge clk);
        cp_wr = 1'b0;
    endtask

    task automatic rd_reg(input int opc2, input int crm, input int exp, input string req);
        @(negedge clk);
        cp_rd = 1'b1; cp_opc2 = 3'(opc2); cp_crm = 4'(crm);
        @(negedge clk);
        cp_rd = 1'b0;
        check(req, int'(cp_rdata), exp);
    endtask

    // Expected victim from the model, then advance the model
    function automatic int predict(input int c, input bit lock);
        int v;
        if (lock) return m_idx[c];
        v = (m_ptr[c] < m_idx[c]) ? m_idx[c] : m_ptr[c];
        m_ptr[c] = (v == NWAYS-1) ? m_idx[c] : v + 1;
        return v;
    endfunction

    task automatic miss(input int c, input bit lock, input string req);
        int e;
        @(negedge clk);
        miss_req = 1'b1; miss_icache = c[0]; miss_loadlock = lock;
        e = predict(c, lock);
        @(negedge clk);
        miss_req = 1'b0; miss_loadlock = 1'b0;
        check({req, " valid"}, int'(victim_valid), 1);
        check(req, int'(victim_way), e);
    endtask

    task automatic set_idx(input int c, input int val);
        wr_reg(c, 0, val);
        m_idx[c] = (val >= NWAYS) ? NWAYS-1 : val;
    endtask

    task automatic t_reset();
        check("R1 valid low", int'(victim_valid), 0);
        rd_reg(0, 0, 0, "R1 data idx");
        rd_reg(1, 0, 0, "R1 instr idx");
    endtask

    task automatic t_regs();
        set_idx(0, 1);
        set_idx(1, 2);
        rd_reg(0, 0, 1, "R2 data idx");
        rd_reg(1, 0, 2, "R2 instr idx");
        rd_reg(2, 0, 0, "R3 bad opc2 read");
        rd_reg(0, 5, 0, "R3 bad crm read");
    endtask

    task automatic t_ignore();
        wr_reg(0, 1, 3);
        wr_reg(4, 0, 3);
        check("R4 no valid", int'(victim_valid), 0);
        rd_reg(0, 0, 1, "R4 data unchanged");
        rd_reg(1, 0, 2, "R4 instr unchanged");
    endtask

    task automatic t_saturate();
        set_idx(0, 9);
        rd_reg(0, 0, 3, "R5 clamp 9");
        set_idx(1, 200);
        rd_reg(1, 0, 3, "R5 clamp 200");
        set_idx(0, 0);
        set_idx(1, 0);
    endtask

    task automatic t_round_robin();
        for (int i = 0; i < 5; i++) miss(0, 1'b0, "R8 data rr idx0");
        miss(1, 1'b0, "R8 instr own ptr");
        miss(1, 1'b0, "R8 instr own ptr");
        set_idx(0, 2);
        for (int i = 0; i < 4; i++) miss(0, 1'b0, "R7 data idx2");
        set_idx(1, 3);
        miss(1, 1'b0, "R7 instr idx3");
        miss(1, 1'b0, "R7 instr idx3");
        @(negedge clk);
        check("R6 idle valid low", int'(victim_valid), 0);
    endtask

    task automatic t_load_lock();
        set_idx(0, 1);
        miss(0, 1'b1, "R9 lock way1");
        set_idx(0, 2);
        miss(0, 1'b1, "R9 lock way2");
        miss(0, 1'b0, "R9 ptr kept");
        miss(0, 1'b0, "R9 ptr kept");
    endtask

    task automatic t_collision();
        int e;
        set_idx(1, 0);
        @(negedge clk);
        cp_wr = 1'b1; cp_opc2 = 3'd1; cp_crm = 4'd0; cp_wdata = 32'd3;
        miss_req = 1'b1; miss_icache = 1'b1; miss_loadlock = 1'b1;
        e = predict(1, 1'b1);
        m_idx[1] = 3;
        @(negedge clk);
        cp_wr = 1'b0; miss_req = 1'b0; miss_loadlock = 1'b0;
        check("R10 old index used", int'(victim_way), e);
        rd_reg(1, 0, 3, "R10 new index stored");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        m_idx[0] = 0; m_idx[1] = 0; m_ptr[0] = 0; m_ptr[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_ignore();
        t_saturate();
        t_round_robin();
        t_load_lock();
        t_collision();
        report();
    end

endmodule